// File: doc/BRIEF.md
# Conversion Result Window Watchdog

This block sits beside the result path of an analog-to-digital converter and checks every conversion result as it goes by. Each result arrives with a valid strobe and the number of the channel it was taken from. The block compares the raw result, before any alignment step, against a programmable low bound and high bound. A monitored result that lies strictly outside the bounds raises a sticky alarm flag. An interrupt line copies the flag when interrupts are enabled.

Software programs the block through a plain write port with a 2-bit register select. One control word holds the enable, the choice between watching every channel and watching one channel, the interrupt enable, and the watched channel number. Two words hold the bounds. A status word clears the alarm when a one is written to its bit 0. The bounds use the same left-aligned layout as the raw result. For a 12-bit converter packed into the top of a 16-bit result, a window of 0x200 to 0xE00 in 12-bit terms is therefore programmed as 0x2000 and 0xE000.

Top module: `adc_window_watch`

## Requirements
- R1: After reset `alarm_flag` and `alarm_irq` are 0, the monitor is disabled, the channel filter is off, the low bound is 0 and the high bound is all ones.
- R2: While control bit 0 (enable, register select 0) is 0, no result changes `alarm_flag`.
- R3: With the monitor enabled, a valid result strictly greater than the high bound (register select 2) sets `alarm_flag` on the clock edge that samples it. For example, 0xE010 against a high bound of 0xE000 sets it.
- R4: With the monitor enabled, a valid result strictly less than the low bound (register select 1) sets `alarm_flag` on the clock edge that samples it. For example, 0x1FF0 against a low bound of 0x2000 sets it.
- R5: A result equal to either bound, or lying between the bounds, does not set `alarm_flag`.
- R6: When control bit 1 (single-channel mode) is 1, only results whose `res_chan` equals control bits [8 +: CH_W] can set the flag. Results from any other channel never affect it.
- R7: When control bit 1 is 0, an out-of-window result on any channel sets the flag.
- R8: Once set, `alarm_flag` stays at 1 through later in-window results until it is cleared.
- R9: A write to register select 3 with data bit 0 at 1 clears `alarm_flag` on that edge. A write there with bit 0 at 0 has no effect.
- R10: When a clear write and a flag-setting result are sampled on the same edge, `alarm_flag` is 1 afterwards.
- R11: `alarm_irq` is 1 exactly when `alarm_flag` is 1 and control bit 2 (interrupt enable) is 1.
- R12: A result presented with `res_valid` at 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 low bound, 2 high bound, 3 status clear |
| wr_data | input | WR_W | Write data |
| res_valid | input | 1 | Conversion result valid |
| res_chan | input | CH_W | Channel number of the result |
| res_data | input | DATA_W | Raw left-aligned conversion result |
| alarm_flag | output | 1 | Sticky out-of-window flag |
| alarm_irq | output | 1 | Flag gated by the interrupt enable |

## Verification
The main comparison is driven from a table of results with a 16-bit window of 0x2000 to 0xE000. The table holds values well inside the window, values exactly on each bound, values one step beyond each bound, and the extreme codes 0x0000 and 0xFFF0. Together these separate strict from inclusive comparison and show the low and high sides work independently. Directed cases then check the channel filter with a matching and a non-matching channel, a violating value presented without its valid strobe, a violation while the monitor is disabled, a status write with bit 0 at 0 against one with bit 0 at 1, and a clear landing on the same edge as a new violation. The interrupt line is tested with the flag both set and clear, under both settings of the interrupt enable.

// File: rtl/adc_ww_pkg.sv
package adc_ww_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_HIGH = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_SGL_BIT = 1;
  localparam int CTRL_IE_BIT  = 2;
  localparam int CTRL_CH_LSB  = 8;
  localparam int STAT_CLR_BIT = 0;

  // strict comparison: a value on either bound is inside
  function automatic logic outside_window(input logic [31:0] value,
                                          input logic [31:0] lo,
                                          input logic [31:0] hi);
    return (value > hi) || (value < lo);
  endfunction

  function automatic logic channel_selected(input logic       single,
                                            input logic [7:0] watched,
                                            input logic [7:0] chan);
    return !single || (watched == chan);
  endfunction

endpackage

// File: rtl/adc_ww_regs.sv
module adc_ww_regs
  import adc_ww_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CH_W   = 5,
  parameter int WR_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WR_W-1:0]   wr_data,
  output logic              mon_en,
  output logic              single_mode,
  output logic              irq_en,
  output logic [CH_W-1:0]   sel_chan,
  output logic [DATA_W-1:0] th_lo,
  output logic [DATA_W-1:0] th_hi,
  output logic              clr_hit
);

  localparam logic [DATA_W-1:0] HI_RESET = '1;

  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_en      <= 1'b0;
      single_mode <= 1'b0;
      irq_en      <= 1'b0;
      sel_chan    <= '0;
      th_lo       <= '0;
      th_hi       <= HI_RESET;
    end else if (wr_en) begin
      case (sel)
        SEL_CTRL: begin
          mon_en      <= wr_data[CTRL_EN_BIT];
          single_mode <= wr_data[CTRL_SGL_BIT];
          irq_en      <= wr_data[CTRL_IE_BIT];
          sel_chan    <= wr_data[CTRL_CH_LSB +: CH_W];
        end
        SEL_LOW:  th_lo <= wr_data[DATA_W-1:0];
        SEL_HIGH: th_hi <= wr_data[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  assign clr_hit = wr_en && (sel == SEL_STAT) && wr_data[STAT_CLR_BIT];

endmodule

// File: rtl/adc_ww_cmp.sv
module adc_ww_cmp
  import adc_ww_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CH_W   = 5
) (
  input  logic              mon_en,
  input  logic              single_mode,
  input  logic [CH_W-1:0]   sel_chan,
  input  logic [DATA_W-1:0] th_lo,
  input  logic [DATA_W-1:0] th_hi,
  input  logic              res_valid,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [DATA_W-1:0] res_data,
  output logic              viol
);

  logic watched;
  logic beyond;

  assign watched = channel_selected(single_mode, 8'(sel_chan), 8'(res_chan));
  assign beyond  = outside_window(32'(res_data), 32'(th_lo), 32'(th_hi));
  assign viol    = res_valid && mon_en && watched && beyond;

endmodule

// File: rtl/adc_ww_flag.sv
module adc_ww_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic viol,
  input  logic clr_hit,
  output logic flag_q
);

  // a new violation outranks a clear on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (viol)    flag_q <= 1'b1;
    else if (clr_hit) flag_q <= 1'b0;
  end

endmodule

// File: rtl/adc_window_watch.sv
module adc_window_watch #(
  parameter int DATA_W = 16,
  parameter int CH_W   = 5,
  parameter int WR_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WR_W-1:0]   wr_data,
  input  logic              res_valid,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [DATA_W-1:0] res_data,
  output logic              alarm_flag,
  output logic              alarm_irq
);

  logic              mon_en;
  logic              single_mode;
  logic              irq_en;
  logic [CH_W-1:0]   sel_chan;
  logic [DATA_W-1:0] th_lo;
  logic [DATA_W-1:0] th_hi;
  logic              clr_hit;
  logic              viol;
  logic              flag_q;

  adc_ww_regs #(.DATA_W(DATA_W), .CH_W(CH_W), .WR_W(WR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mon_en(mon_en), .single_mode(single_mode),
    .irq_en(irq_en), .sel_chan(sel_chan), .th_lo(th_lo), .th_hi(th_hi),
    .clr_hit(clr_hit)
  );

  adc_ww_cmp #(.DATA_W(DATA_W), .CH_W(CH_W)) u_cmp (
    .mon_en(mon_en), .single_mode(single_mode), .sel_chan(sel_chan),
    .th_lo(th_lo), .th_hi(th_hi), .res_valid(res_valid),
    .res_chan(res_chan), .res_data(res_data), .viol(viol)
  );

  adc_ww_flag u_flag (
    .clk(clk), .rst_n(rst_n), .viol(viol), .clr_hit(clr_hit), .flag_q(flag_q)
  );

  assign alarm_flag = flag_q;
  assign alarm_irq  = flag_q && irq_en;

endmodule

// File: rtl/adc_ww_chk.sv
module adc_ww_chk #(
  parameter int CH_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            alarm_flag,
  input logic            alarm_irq,
  input logic            viol,
  input logic            clr_hit,
  input logic            res_valid,
  input logic [CH_W-1:0] res_chan,
  input logic            single_mode,
  input logic [CH_W-1:0] sel_chan
);

  assert_violation_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> alarm_flag);

  assert_set_needs_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(viol));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !clr_hit) |=> alarm_flag);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !viol) |=> !alarm_flag);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && viol) |=> alarm_flag);

  assert_unwatched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && single_mode && (res_chan != sel_chan)) |-> !viol);

  assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> alarm_flag);

  assert_invalid_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !viol);

endmodule

bind adc_window_watch adc_ww_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq),
  .viol(viol), .clr_hit(clr_hit), .res_valid(res_valid), .res_chan(res_chan),
  .single_mode(single_mode), .sel_chan(sel_chan)
);

// File: tb/test_adc_window_watch.sv
module test_adc_window_watch;

  localparam int DATA_W = 16;
  localparam int CH_W   = 5;
  localparam int WR_W   = 32;
  localparam int NVEC   = 8;

  // {channel, result, expected flag}
  localparam logic [CH_W+DATA_W:0] VEC [NVEC] = '{
    {5'd0,  16'h8000, 1'b0},
    {5'd1,  16'h2000, 1'b0},
    {5'd2,  16'hE000, 1'b0},
    {5'd3,  16'h1FF0, 1'b1},
    {5'd4,  16'hE010, 1'b1},
    {5'd7,  16'h0000, 1'b1},
    {5'd9,  16'hFFF0, 1'b1},
    {5'd12, 16'h2010, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = '0;
  logic [WR_W-1:0]   wr_data = '0;
  logic              res_valid = 1'b0;
  logic [CH_W-1:0]   res_chan = '0;
  logic [DATA_W-1:0] res_data = '0;
  logic              alarm_flag;
  logic              alarm_irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  adc_window_watch #(.DATA_W(DATA_W), .CH_W(CH_W), .WR_W(WR_W)) i_adc_window_watch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [WR_W-1:0] ctrl_word(input logic en, input logic sgl,
                                                input logic ie, input int ch);
    logic [WR_W-1:0] w;
    w = '0;
    w[0] = en;
    w[1] = sgl;
    w[2] = ie;
    w[8 +: CH_W] = CH_W'(ch);
    return w;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // drive at falling edge, sampled at next rising edge, released at following fall
  task automatic write_reg(input logic [1:0] a, input logic [WR_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic push(input int ch, input logic [DATA_W-1:0] d, input logic v);
    res_valid = v; res_chan = CH_W'(ch); res_data = d;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flag after reset", alarm_flag, 1'b0);
    check("R1 irq after reset", alarm_irq, 1'b0);

    write_reg(2'd1, 32'h2000);
    write_reg(2'd2, 32'hE000);
    push(3, 16'h0000, 1'b1);
    check("R2 disabled ignores low result", alarm_flag, 1'b0);
    push(3, 16'hFFFF, 1'b1);
    check("R2 disabled ignores high result", alarm_flag, 1'b0);

    write_reg(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 0));
    for (int i = 0; i < NVEC; i++) begin
      push(int'(VEC[i][CH_W+DATA_W:DATA_W+1]), VEC[i][DATA_W:1], 1'b1);
      check($sformatf("R3 R4 R5 R7 vector %0d", i), alarm_flag, VEC[i][0]);
      write_reg(2'd3, 32'h1);
      check($sformatf("R9 cleared after vector %0d", i), alarm_flag, 1'b0);
    end

    push(4, 16'h0000, 1'b0);
    check("R12 invalid result ignored", alarm_flag, 1'b0);

    push(6, 16'hF000, 1'b1);
    check("R11 irq off while disabled", alarm_irq, 1'b0);
    push(6, 16'h8000, 1'b1);
    push(2, 16'h2000, 1'b1);
    check("R8 flag held through in-window results", alarm_flag, 1'b1);
    write_reg(2'd0, ctrl_word(1'b1, 1'b0, 1'b1, 0));
    check("R11 irq follows flag when enabled", alarm_irq, 1'b1);
    write_reg(2'd3, 32'h0);
    check("R9 write of zero keeps flag", alarm_flag, 1'b1);
    write_reg(2'd3, 32'h1);
    check("R9 write of one clears flag", alarm_flag, 1'b0);
    check("R11 irq low with flag clear", alarm_irq, 1'b0);

    push(1, 16'hE000, 1'b1);
    check("R5 equal to high bound", alarm_flag, 1'b0);
    push(1, 16'h2000, 1'b1);
    check("R5 equal to low bound", alarm_flag, 1'b0);

    push(1, 16'h0100, 1'b1);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 32'h1;
    res_valid = 1'b1; res_chan = 5'd2; res_data = 16'hFF00;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; res_valid = 1'b0;
    check("R10 violation beats clear", alarm_flag, 1'b1);
    write_reg(2'd3, 32'h1);

    write_reg(2'd0, ctrl_word(1'b1, 1'b1, 1'b1, 6));
    push(5, 16'h0000, 1'b1);
    check("R6 other channel ignored", alarm_flag, 1'b0);
    push(7, 16'hFFFF, 1'b1);
    check("R6 other channel ignored high", alarm_flag, 1'b0);
    push(6, 16'hFFFF, 1'b1);
    check("R6 watched channel flags", alarm_flag, 1'b1);
    check("R11 irq set in single mode", alarm_irq, 1'b1);

    write_reg(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 6));
    check("R11 irq dropped by disabling", alarm_irq, 1'b0);
    check("R8 flag kept across control write", alarm_flag, 1'b1);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset clears flag", alarm_flag, 1'b0);
    push(3, 16'h0000, 1'b1);
    check("R1 monitor disabled after reset", alarm_flag, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  end

endmodule